// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Controller

This block is the digital control core of a clock generator with four differential output pairs and one single-ended reference output. It watches a combined power-good / power-down pin. On the first rising edge of that pin after reset, it captures two board straps. The first strap chooses one of two 7-bit management-bus addresses. The second is a three-level strap that picks the spread-spectrum depth. After that first edge, the same pin acts only as a power-down control: a low level parks every output and a high level releases them.

Each differential pair gets a run/park decision built from four conditions: power is good, the PLL reports lock, the pair's active-low enable pin is 0, and the pair's register enable bit is 1. A parked pair holds both its true and complement lines low. The register enable bits come from an external register file, which should reset them to 1 so that the pins alone govern the outputs when nothing is written.

A pair's state only changes in a cycle where the output-clock divider marks a safe point (`clean_pt`). This keeps a gated clock from emitting a truncated pulse. The power-good pin, the enable pins and the lock flag all pass through synchronizers before use.

The reference output has three states. It floats until the first power-good edge. After that it is parked low during power-down and runs otherwise.

Top module: `ckgen_outctl`

## Requirements
- R1: The address and spread straps are captured only on the first rising edge of the synchronized power-good input after reset. Later rising edges leave `smb_addr` and `spread_sel` unchanged.
- R2: After the first power-good edge, a low power-good input means power-down and a high level means normal operation. Power-down can be entered and left any number of times.
- R3: `ref_drive` stays 0 (reference floating) from reset until the first power-good edge, and stays 1 after that. `ref_toggle` is 1 exactly when `ref_drive` is 1 and power is good, and 0 during power-down.
- R4: During power-down every bit of `pair_run` goes to 0 (both lines of each pair low), whatever the enable pins and bits are.
- R5: With power good and PLL lock, pair i runs (`pair_run[i]`=1) only when `oe_pin_n[i]`=0 and `en_bit[i]`=1. Otherwise it parks.
- R6: While `pll_lock` is 0, every `pair_run` bit is 0.
- R7: `smb_addr` is 7'b1101000 when the captured address strap is 0, and 7'b1101010 when it is 1.
- R8: The spread strap arrives as a two-bit level reading {above_mid, above_low}. 00 (low) maps to `spread_sel`=00 (spread off). 01 (mid) maps to 01 (-0.25%). 11 (high) maps to 10 (-0.5%). The inconsistent reading 10 is treated as high. `spread_sel` is never 11.
- R9: A `pair_run` bit changes only at a clock edge where `clean_pt` was 1. While `clean_pt` stays 0, pairs hold their state even if their conditions change.
- R10: After reset, `pair_run`=0, `ref_drive`=0, `ref_toggle`=0, `smb_addr`=7'b1101000 and `spread_sel`=00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok_in | input | 1 | Power-good (high) / power-down (low) pin, asynchronous |
| oe_pin_n | input | NOUT | Active-low per-pair enable pins, asynchronous |
| en_bit | input | NOUT | Per-pair register enable bits, 1 = allowed |
| pll_lock | input | 1 | PLL lock flag, asynchronous |
| addr_strap | input | 1 | Address-select strap level |
| ss_strap | input | 2 | Spread strap level reading {above_mid, above_low} |
| clean_pt | input | 1 | Safe point for output gating changes |
| pair_run | output | NOUT | Per-pair 1 = running, 0 = both lines parked low |
| ref_drive | output | 1 | Reference driver enabled (0 = high impedance) |
| ref_toggle | output | 1 | Reference running (1) or parked low (0) |
| smb_addr | output | 7 | Decoded management-bus address |
| spread_sel | output | 2 | Spread code: 00 off, 01 -0.25%, 10 -0.5% |

## Verification
The assertions assume that the strap levels are stable around the first power-good edge. They also assume that `clean_pt` comes from the same clock as the block, so its sampled value is meaningful at each edge. The stimulus sets the straps several cycles before it raises power-good, and changes them only when the captured values should already be frozen. The asynchronous pins are changed half a cycle away from the active edge, and each decision is sampled only after the synchronizer and state registers have settled. The lock and enable sweeps hold `clean_pt` high, except in the dedicated sequence that holds it low to show that the pairs stay where they are.

// File: rtl/ckgen_outctl.sv
module ckgen_outctl #(
  parameter int NOUT = 4,
  parameter int SYNC = 2,
  parameter logic [6:0] ADDR_LO = 7'b1101000,
  parameter logic [6:0] ADDR_HI = 7'b1101010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_ok_in,
  input  logic [NOUT-1:0] oe_pin_n,
  input  logic [NOUT-1:0] en_bit,
  input  logic            pll_lock,
  input  logic            addr_strap,
  input  logic [1:0]      ss_strap,
  input  logic            clean_pt,
  output logic [NOUT-1:0] pair_run,
  output logic            ref_drive,
  output logic            ref_toggle,
  output logic [6:0]      smb_addr,
  output logic [1:0]      spread_sel
);
  localparam int LAST = SYNC - 1;

  typedef enum logic {PARKED = 1'b0, RUNNING = 1'b1} pair_st_t;

  logic [SYNC-1:0] pg_sync, lock_sync;
  logic [NOUT-1:0] oe_sync [SYNC];
  logic            pg_d, started, addr_q;
  logic [1:0]      ss_q;
  logic            pg_s, lock_s, first_rise;
  logic [NOUT-1:0] oe_s, want;

  assign pg_s   = pg_sync[LAST];
  assign lock_s = lock_sync[LAST];
  assign oe_s   = oe_sync[LAST];
  assign first_rise = pg_s & ~pg_d & ~started;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_sync   <= '0;
      lock_sync <= '0;
      pg_d      <= 1'b0;
    end else begin
      pg_sync   <= {pg_sync[SYNC-2:0], pwr_ok_in};
      lock_sync <= {lock_sync[SYNC-2:0], pll_lock};
      pg_d      <= pg_s;
    end
  end

  generate
    for (genvar k = 0; k < SYNC; k++) begin : g_oe_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_sync[k] <= '1;
        else if (k == 0) oe_sync[k] <= oe_pin_n;
        else oe_sync[k] <= oe_sync[(k == 0) ? 0 : k-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      addr_q  <= 1'b0;
      ss_q    <= 2'b00;
    end else if (first_rise) begin
      started <= 1'b1;
      addr_q  <= addr_strap;
      ss_q    <= ss_strap[1] ? 2'b10 : (ss_strap[0] ? 2'b01 : 2'b00);
    end
  end

  assign smb_addr   = addr_q ? ADDR_HI : ADDR_LO;
  assign spread_sel = ss_q;
  assign ref_drive  = started;
  assign ref_toggle = started & pg_s;

  assign want = {NOUT{ref_toggle & lock_s}} & ~oe_s & en_bit;

  generate
    for (genvar i = 0; i < NOUT; i++) begin : g_pair
      pair_st_t st;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= PARKED;
        else if (clean_pt) st <= want[i] ? RUNNING : PARKED;
      end
      assign pair_run[i] = (st == RUNNING);
    end
  endgenerate
endmodule

module ckgen_outctl_chk #(
  parameter int NOUT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clean_pt,
  input logic [NOUT-1:0] pair_run,
  input logic            ref_drive,
  input logic            ref_toggle,
  input logic [6:0]      smb_addr,
  input logic [1:0]      spread_sel
);
  p_ref_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_drive |=> ref_drive);
  p_toggle_needs_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_toggle |-> ref_drive);
  p_strap_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ref_drive) |-> ($stable(smb_addr) && $stable(spread_sel)));
  p_addr_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smb_addr == 7'b1101000) || (smb_addr == 7'b1101010));
  p_code_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spread_sel != 2'b11);

  generate
    for (genvar i = 0; i < NOUT; i++) begin : g_pair_chk
      p_clean_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pair_run[i]) |-> $past(clean_pt));
      p_rise_powered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pair_run[i]) |-> $past(ref_toggle));
      p_park_in_pd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_toggle && clean_pt) |=> !pair_run[i]);
    end
  endgenerate
endmodule

bind ckgen_outctl ckgen_outctl_chk #(.NOUT(NOUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .clean_pt(clean_pt), .pair_run(pair_run),
  .ref_drive(ref_drive), .ref_toggle(ref_toggle), .smb_addr(smb_addr),
  .spread_sel(spread_sel)
);

// File: tb/tb_ckgen_outctl.sv
module tb_ckgen_outctl;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_ok_in = 1'b0;
  logic [N-1:0] oe_pin_n = '1;
  logic [N-1:0] en_bit = '1;
  logic pll_lock = 1'b0;
  logic addr_strap = 1'b0;
  logic [1:0] ss_strap = 2'b00;
  logic clean_pt = 1'b1;
  logic [N-1:0] pair_run;
  logic ref_drive, ref_toggle;
  logic [6:0] smb_addr;
  logic [1:0] spread_sel;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ckgen_outctl #(.NOUT(N)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok_in(pwr_ok_in), .oe_pin_n(oe_pin_n),
    .en_bit(en_bit), .pll_lock(pll_lock), .addr_strap(addr_strap),
    .ss_strap(ss_strap), .clean_pt(clean_pt), .pair_run(pair_run),
    .ref_drive(ref_drive), .ref_toggle(ref_toggle), .smb_addr(smb_addr),
    .spread_sel(spread_sel)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    pwr_ok_in = 1'b0;
    settle(3);
    rst_n = 1'b1;
    settle(1);
  endtask

  function automatic logic [1:0] ss_code(input logic [1:0] lvl);
    return lvl[1] ? 2'b10 : (lvl[0] ? 2'b01 : 2'b00);
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    chk("R10 pair_run", pair_run, 0);
    chk("R10 ref_drive", ref_drive, 0);
    chk("R10 ref_toggle", ref_toggle, 0);
    chk("R10 smb_addr", smb_addr, 7'b1101000);
    chk("R10 spread_sel", spread_sel, 0);

    // R3/R6: before first power-good, everything parked, reference floating
    oe_pin_n = '0; en_bit = '1; pll_lock = 1'b1;
    settle(10);
    chk("R3 float before start", ref_drive, 0);
    chk("R6 parked before start", pair_run, 0);

    // R1 R7 R8 first edge captures straps
    addr_strap = 1'b1; ss_strap = 2'b01;
    settle(3);
    pwr_ok_in = 1'b1;
    settle(10);
    chk("R7 addr hi", smb_addr, 7'b1101010);
    chk("R8 mid", spread_sel, 2'b01);
    chk("R3 drive after start", ref_drive, 1);
    chk("R3 running", ref_toggle, 1);
    chk("R5 all run", pair_run, 4'hF);

    // R2 R4: power-down parks regardless of enables
    addr_strap = 1'b0; ss_strap = 2'b11;
    pwr_ok_in = 1'b0;
    settle(10);
    chk("R4 pd parks", pair_run, 0);
    chk("R3 parked low in pd", {ref_drive, ref_toggle}, 2'b10);
    pwr_ok_in = 1'b1;
    settle(10);
    chk("R2 exit pd", pair_run, 4'hF);
    chk("R1 addr frozen", smb_addr, 7'b1101010);
    chk("R1 spread frozen", spread_sel, 2'b01);

    // R4 R5 R6 sweep over pins, bits, lock and power
    for (int v = 0; v < 512; v++) begin
      logic [N-1:0] exp_run;
      oe_pin_n = v[3:0];
      en_bit = v[7:4];
      pll_lock = v[8];
      pwr_ok_in = 1'b1;
      settle(8);
      exp_run = v[8] ? (~v[3:0] & v[7:4]) : 4'h0;
      chk(v[8] ? "R5 pin/bit gating" : "R6 no lock parks", pair_run, exp_run);
      pwr_ok_in = 1'b0;
      settle(8);
      chk("R4 pd sweep", pair_run, 0);
      chk("R2 ref in pd", ref_toggle, 0);
    end

    // R9 clean-point gating
    pwr_ok_in = 1'b1; pll_lock = 1'b1; oe_pin_n = '0; en_bit = '1; clean_pt = 1'b1;
    settle(8);
    chk("R9 setup run", pair_run, 4'hF);
    clean_pt = 1'b0;
    oe_pin_n = 4'b0101;
    settle(10);
    chk("R9 hold without clean point", pair_run, 4'hF);
    clean_pt = 1'b1;
    settle(1);
    chk("R9 change at clean point", pair_run, 4'b1010);
    clean_pt = 1'b0;
    oe_pin_n = '0;
    settle(10);
    chk("R9 hold park", pair_run, 4'b1010);
    clean_pt = 1'b1;
    settle(1);
    chk("R9 resume", pair_run, 4'hF);

    // R7 R8 decode over all strap combinations, fresh reset each time
    for (int s = 0; s < 8; s++) begin
      do_reset();
      addr_strap = s[2];
      ss_strap = s[1:0];
      settle(3);
      pwr_ok_in = 1'b1;
      settle(8);
      chk("R7 addr decode", smb_addr, s[2] ? 7'b1101010 : 7'b1101000);
      chk("R8 spread decode", spread_sel, ss_code(s[1:0]));
      addr_strap = ~s[2];
      ss_strap = ~s[1:0];
      pwr_ok_in = 1'b0;
      settle(6);
      pwr_ok_in = 1'b1;
      settle(6);
      chk("R1 no relatch", {smb_addr, spread_sel},
          {(s[2] ? 7'b1101010 : 7'b1101000), ss_code(s[1:0])});
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule